// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Alarm

This block keeps wall-clock time in four packed BCD bytes: tenths of a second, seconds, minutes, and a 12-hour hours byte that carries a PM flag in its top bit. A mains-derived tick pulse enters a prescaler. The prescaler divides by five or by six, chosen by a frequency-select input, and its output advances the tenths digit. A carry chain then ripples through seconds, minutes and hours.

A simple register port sits alongside the clock. Software sets the time, or programs an alarm of the same shape, through this port. A selector input decides which of the two register sets a write lands in.

Reading the time is made coherent by a read view:
- Reading the hours byte freezes the four bytes presented on the read data port, while the clock keeps counting underneath.
- Reading the tenths byte releases the freeze.

Setting the time is made coherent in a similar way. Writing the hours byte stops the clock, and writing the tenths byte starts it again. Whenever a tenths advance leaves the time equal to the alarm, the block raises a one-cycle alarm pulse.

Top module: `tod_clock`

## Requirements
- R1: After reset, all four time bytes read 0x00, alarm_o is 0, the clock is running, the read view is not frozen, the alarm bytes are 0x00 and the prescaler count is 0.
- R2: Each tick_i pulse that is accepted decrements the prescaler count. When the count is 0, the tick instead advances tenths and reloads the count: with 4 when freq50_i is 1 (an advance every 5 ticks) and with 5 when freq50_i is 0 (an advance every 6 ticks). Because reset leaves the count at 0, the first accepted tick after reset advances tenths.
- R3: Tenths count from 0 to 9 and wrap to 0 with a carry into seconds. Seconds and minutes are two-digit BCD: the low digit wraps from 9 to 0 with a carry into the high digit, and 59 wraps to 00 with a carry into the next field.
- R4: Hours bits 4:0 count BCD from 00 to 11, and 09 goes to 10. When hours would pass 11, bits 4:0 become 00 and bit 7 (PM) toggles.
- R5: Written bytes are masked before storage. The masks are 0x0F for tenths, 0x7F for seconds, 0x7F for minutes and 0x9F for hours. Address encoding is 0 = tenths, 1 = seconds, 2 = minutes, 3 = hours.
- R6: A write with alarm_sel_i = 1 stores into the alarm bytes and leaves the time bytes unchanged. A write with alarm_sel_i = 0 stores into the time bytes.
- R7: A time write to hours stops the clock, and ticks are then ignored. A time write to tenths restarts the clock. Writes to the alarm bytes never stop or start the clock.
- R8: A read strobe at address 3 freezes the bytes shown on rdata_o at their values in that cycle, while counting continues. A read strobe at address 0 shows the frozen tenths in that cycle and releases the view afterwards. rdata_o is combinational from addr_i.
- R9: alarm_o is high for exactly the one cycle in which the time bytes first show a value that a tenths advance produced and that equals all four alarm bytes. A bus write that makes the time equal to the alarm raises no pulse.
- R10: If a time write and an accepted tick fall in the same cycle, the write takes effect and the tick is dropped. Neither the tenths nor the prescaler move in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle mains tick pulse |
| freq50_i | input | 1 | 1: divide ticks by 5, 0: divide by 6 |
| alarm_sel_i | input | 1 | 1: writes go to the alarm bytes |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (drives freeze/release) |
| addr_i | input | 2 | Byte select: 0 tenths, 1 sec, 2 min, 3 hours |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data from the read view |
| alarm_o | output | 1 | One-cycle alarm pulse |

## Verification
The assertions check the following on every cycle:
- the prescaler count stays within range;
- a halted clock keeps its tenths still;
- an hours write halts the clock;
- the alarm pulse lasts one cycle and only ever follows an advance;
- a frozen snapshot does not change.

Only the bench scenarios can show the following:
- the actual divide ratios, including a ratio switch part-way through;
- the BCD carry chain with its 59-to-00 and 11-to-00 PM wrap;
- the write masks;
- routing of writes to the alarm bytes;
- the values seen through a freeze while the clock moves on;
- a tick dropped when it collides with a write.

// File: rtl/tod_pkg.sv
// Package: shared sizes, field indices, masks and BCD increment helpers
// for the time-of-day clock. Assumes 8-bit bus bytes and four fields.
package tod_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned NUM_FIELDS = 4;
    localparam int unsigned ADDR_W     = $clog2(NUM_FIELDS);

    localparam int unsigned F_TENTHS = 0;
    localparam int unsigned F_SEC    = 1;
    localparam int unsigned F_MIN    = 2;
    localparam int unsigned F_HOUR   = 3;

    typedef logic [NUM_FIELDS-1:0][BYTE_W-1:0] tod_bytes_t;

    // Storage mask for a field index
    function automatic logic [BYTE_W-1:0] field_mask(input int unsigned idx);
        case (idx)
            F_TENTHS: field_mask = 8'h0F;
            F_SEC:    field_mask = 8'h7F;
            F_MIN:    field_mask = 8'h7F;
            default:  field_mask = 8'h9F;
        endcase
    endfunction

    // Tenths step: returns {carry, next}
    function automatic logic [BYTE_W:0] tenths_inc(input logic [BYTE_W-1:0] v);
        logic [4:0] lo;
        lo = {1'b0, v[3:0]} + 5'd1;
        if (lo > 5'd9) tenths_inc = {1'b1, 8'h00};
        else           tenths_inc = {1'b0, 4'h0, lo[3:0]};
    endfunction

    // Two-digit base-60 BCD step: returns {carry, next}
    function automatic logic [BYTE_W:0] sexa_inc(input logic [BYTE_W-1:0] v);
        logic [4:0] lo;
        logic [3:0] hi;
        lo = {1'b0, v[3:0]} + 5'd1;
        hi = {1'b0, v[6:4]};
        if (lo > 5'd9) begin
            lo = 5'd0;
            hi = hi + 4'd1;
        end
        if (hi > 4'd5) sexa_inc = {1'b1, 8'h00};
        else           sexa_inc = {1'b0, 1'b0, hi[2:0], lo[3:0]};
    endfunction

    // 12-hour BCD step with PM toggle at the wrap past 11
    function automatic logic [BYTE_W-1:0] hour_inc(input logic [BYTE_W-1:0] v);
        logic [4:0] lo;
        logic [1:0] hi;
        logic [5:0] val;
        lo = {1'b0, v[3:0]} + 5'd1;
        hi = {1'b0, v[4]};
        if (lo > 5'd9) begin
            lo = 5'd0;
            hi = hi + 2'd1;
        end
        val = {hi, lo[3:0]};
        if (val > 6'h11) hour_inc = {~v[7], 7'h00};
        else             hour_inc = {v[7], 2'b00, val[4:0]};
    endfunction

endpackage

// File: rtl/tod_prescaler.sv
// Module: tod_prescaler
// Divides accepted mains ticks down to tenth-of-second advances. The
// count sits at zero after reset; a step at zero advances and reloads.
// Assumes step_i is already qualified (clock running, no write collision).
module tod_prescaler #(
    parameter int unsigned DIV_FAST = 5,
    parameter int unsigned DIV_SLOW = 6,
    localparam int unsigned CNT_W   = $clog2(DIV_SLOW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             fast_i,
    output logic             adv_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] RELOAD_FAST = CNT_W'(DIV_FAST - 1);
    localparam logic [CNT_W-1:0] RELOAD_SLOW = CNT_W'(DIV_SLOW - 1);

    logic [CNT_W-1:0] cnt_q;

    // Advance exactly when a step arrives with the count exhausted
    always_comb adv_o = step_i && (cnt_q == '0);

    // Decrement on each step, reload on the advancing step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step_i) begin
            if (cnt_q == '0) cnt_q <= fast_i ? RELOAD_FAST : RELOAD_SLOW;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/tod_time_regs.sv
// Module: tod_time_regs
// Holds the live time bytes and the run/halt flag. A bus write has
// priority over an advance. Exposes the post-advance value so that the
// alarm comparator can match it in the same cycle.
module tod_time_regs
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output tod_bytes_t        time_o,
    output tod_bytes_t        next_o,
    output logic              running_o
);

    tod_bytes_t  time_q;
    tod_bytes_t  inc_val;
    logic [BYTE_W:0] t_step, s_step, m_step;
    logic        running_q;

    // Carry chain: each field steps only when all lower fields wrap
    always_comb begin
        t_step = tenths_inc(time_q[F_TENTHS]);
        s_step = sexa_inc(time_q[F_SEC]);
        m_step = sexa_inc(time_q[F_MIN]);
        inc_val = time_q;
        inc_val[F_TENTHS] = t_step[BYTE_W-1:0];
        if (t_step[BYTE_W]) begin
            inc_val[F_SEC] = s_step[BYTE_W-1:0];
            if (s_step[BYTE_W]) begin
                inc_val[F_MIN] = m_step[BYTE_W-1:0];
                if (m_step[BYTE_W]) inc_val[F_HOUR] = hour_inc(time_q[F_HOUR]);
            end
        end
    end

    // Value the registers take after this cycle's advance, if any
    always_comb next_o = adv_i ? inc_val : time_q;

    // Per-field storage: write wins, else advance, else hold
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        always_ff @(posedge clk) begin
            if (!rst_n)
                time_q[g] <= '0;
            else if (wr_i && (addr_i == ADDR_W'(g)))
                time_q[g] <= wdata_i & field_mask(g);
            else if (!wr_i && adv_i)
                time_q[g] <= inc_val[g];
        end
    end

    // Run flag: hours write halts, tenths write restarts
    always_ff @(posedge clk) begin
        if (!rst_n)
            running_q <= 1'b1;
        else if (wr_i && (addr_i == ADDR_W'(F_HOUR)))
            running_q <= 1'b0;
        else if (wr_i && (addr_i == ADDR_W'(F_TENTHS)))
            running_q <= 1'b1;
    end

    assign time_o    = time_q;
    assign running_o = running_q;

endmodule

// File: rtl/tod_alarm_unit.sv
// Module: tod_alarm_unit
// Stores the alarm bytes and raises a one-cycle pulse when an advance
// produces a time equal to them. Assumes next_i is the post-advance value.
module tod_alarm_unit
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              adv_i,
    input  tod_bytes_t        next_i,
    output logic              alarm_o
);

    tod_bytes_t alarm_q;
    logic [NUM_FIELDS-1:0] field_eq;

    // Alarm byte storage, masked like the time bytes
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_alm
        always_ff @(posedge clk) begin
            if (!rst_n)
                alarm_q[g] <= '0;
            else if (wr_i && (addr_i == ADDR_W'(g)))
                alarm_q[g] <= wdata_i & field_mask(g);
        end
        always_comb field_eq[g] = (next_i[g] == alarm_q[g]);
    end

    // Pulse register: set only by an advance that lands on the alarm
    always_ff @(posedge clk) begin
        if (!rst_n) alarm_o <= 1'b0;
        else        alarm_o <= adv_i && (&field_eq);
    end

endmodule

// File: rtl/tod_read_view.sv
// Module: tod_read_view
// Presents time bytes to the bus. A read strobe on hours snapshots all
// bytes and freezes the view; a read strobe on tenths releases it.
module tod_read_view
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  tod_bytes_t        live_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              frozen_o,
    output tod_bytes_t        snap_o
);

    tod_bytes_t snap_q;
    logic       frozen_q;
    logic       take_snap;

    // Snapshot only on the first hours read of a freeze
    always_comb take_snap = rd_i && (addr_i == ADDR_W'(F_HOUR)) && !frozen_q;

    // Snapshot registers, one per field
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_snap
        always_ff @(posedge clk) begin
            if (!rst_n)         snap_q[g] <= '0;
            else if (take_snap) snap_q[g] <= live_i[g];
        end
    end

    // Freeze flag: set by an hours read, cleared by a tenths read
    always_ff @(posedge clk) begin
        if (!rst_n)
            frozen_q <= 1'b0;
        else if (rd_i && (addr_i == ADDR_W'(F_HOUR)))
            frozen_q <= 1'b1;
        else if (rd_i && (addr_i == ADDR_W'(F_TENTHS)))
            frozen_q <= 1'b0;
    end

    // Byte mux from the frozen or the live set
    always_comb rdata_o = frozen_q ? snap_q[addr_i] : live_i[addr_i];

    assign frozen_o = frozen_q;
    assign snap_o   = snap_q;

endmodule

// File: rtl/tod_clock.sv
// Module: tod_clock (top)
// 12-hour BCD time-of-day clock with alarm. Combines the prescaler, the
// time registers, the alarm unit and the read view. Assumes tick_i is a
// clean single-cycle pulse synchronous to clk.
module tod_clock
    import tod_pkg::*;
#(
    parameter int unsigned DIV_FAST = 5,
    parameter int unsigned DIV_SLOW = 6,
    localparam int unsigned CNT_W   = $clog2(DIV_SLOW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              freq50_i,
    input  logic              alarm_sel_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              alarm_o
);

    logic             wr_time, wr_alarm;
    logic             running, step, adv;
    logic [CNT_W-1:0] presc_cnt;
    tod_bytes_t       live_time, next_time, snap;
    logic             frozen;

    // Route a write to one register set
    always_comb begin
        wr_time  = wr_en_i && !alarm_sel_i;
        wr_alarm = wr_en_i &&  alarm_sel_i;
    end

    // Accept a tick only while running and not colliding with a time write
    always_comb step = tick_i && running && !wr_time;

    tod_prescaler #(
        .DIV_FAST(DIV_FAST),
        .DIV_SLOW(DIV_SLOW)
    ) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .fast_i (freq50_i),
        .adv_o  (adv),
        .cnt_o  (presc_cnt)
    );

    tod_time_regs u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_i     (adv),
        .wr_i      (wr_time),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .time_o    (live_time),
        .next_o    (next_time),
        .running_o (running)
    );

    tod_alarm_unit u_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_alarm),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .adv_i   (adv),
        .next_i  (next_time),
        .alarm_o (alarm_o)
    );

    tod_read_view u_view (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (rd_en_i),
        .addr_i   (addr_i),
        .live_i   (live_time),
        .rdata_o  (rdata_o),
        .frozen_o (frozen),
        .snap_o   (snap)
    );

endmodule

// File: rtl/tod_clock_chk.sv
// Module: tod_clock_chk
// Property checker for tod_clock, bound to the top module. Observes ports
// and the signals that link the submodules.
module tod_clock_chk
    import tod_pkg::*;
#(
    parameter int unsigned DIV_SLOW = 6,
    localparam int unsigned CNT_W   = $clog2(DIV_SLOW)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic              alarm_sel_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              alarm_o,
    input logic              adv,
    input logic              running,
    input logic [CNT_W-1:0]  presc_cnt,
    input logic              frozen,
    input tod_bytes_t        snap,
    input tod_bytes_t        live_time
);

    AST_PRESC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        presc_cnt < CNT_W'(DIV_SLOW)); // R2

    AST_HOURS_WR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !alarm_sel_i && addr_i == ADDR_W'(F_HOUR)) |=> !running); // R7

    AST_HALT_HOLDS_TENTHS: assert property (@(posedge clk) disable iff (!rst_n)
        (!running ##1 !running) |-> $stable(live_time[F_TENTHS])); // R7

    AST_ALARM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |=> !alarm_o); // R9

    AST_ALARM_AFTER_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_o) |-> $past(adv)); // R9

    AST_HOURS_RD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADDR_W'(F_HOUR)) |=> frozen); // R8

    AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen ##1 frozen) |-> $stable(snap)); // R8

endmodule

bind tod_clock tod_clock_chk #(.DIV_SLOW(DIV_SLOW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .alarm_sel_i (alarm_sel_i),
    .addr_i      (addr_i),
    .alarm_o     (alarm_o),
    .adv         (adv),
    .running     (running),
    .presc_cnt   (presc_cnt),
    .frozen      (frozen),
    .snap        (snap),
    .live_time   (live_time)
);

// File: tb/tod_clock_tb.sv
// Scoreboard bench for tod_clock: driver tasks push expected items into a
// queue at a falling edge; a monitor pops and compares them shortly after.
module tod_clock_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0, freq50_i = 1'b1, alarm_sel_i = 1'b0;
    logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
    logic [1:0] addr_i = 2'd0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic       alarm_o;

    typedef struct {
        bit         is_alarm;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;

    tod_clock u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .freq50_i(freq50_i),
        .alarm_sel_i(alarm_sel_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .alarm_o(alarm_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: compare every queued expectation after the falling edge
    always @(negedge clk) begin
        #2;
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = it.is_alarm ? {7'b0, alarm_o} : rdata_o;
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic exp_rd(input logic [1:0] a, input logic [7:0] e, input bit strobe, input string tag);
        addr_i  = a;
        rd_en_i = strobe;
        sb_q.push_back('{1'b0, e, tag});
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic exp_alarm(input bit e, input string tag);
        sb_q.push_back('{1'b1, {7'b0, e}, tag});
    endtask

    task automatic wr(input bit sel, input logic [1:0] a, input logic [7:0] d, input bit with_tick);
        alarm_sel_i = sel;
        addr_i      = a;
        wdata_i     = d;
        wr_en_i     = 1'b1;
        tick_i      = with_tick;
        @(negedge clk);
        wr_en_i     = 1'b0;
        tick_i      = 1'b0;
        alarm_sel_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
            @(negedge clk);
        end
    endtask

    // n ticks; check the alarm output in the cycle after the last one
    task automatic ticks_alarm(input int n, input bit e, input string tag);
        if (n > 1) ticks(n - 1);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        exp_alarm(e, tag);
        @(negedge clk);
    endtask

    task automatic exp_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                            input logic [7:0] t, input string tag);
        exp_rd(2'd3, h, 1'b0, {tag, " hours"});
        exp_rd(2'd2, m, 1'b0, {tag, " minutes"});
        exp_rd(2'd1, s, 1'b0, {tag, " seconds"});
        exp_rd(2'd0, t, 1'b0, {tag, " tenths"});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        exp_alarm(1'b0, "R1 alarm after reset");
        exp_time(8'h00, 8'h00, 8'h00, 8'h00, "R1 reset");

        // R2: first tick advances, then divide by 5
        freq50_i = 1'b1;
        ticks(1);
        exp_rd(2'd0, 8'h01, 1'b0, "R2 first tick advances");
        ticks(4);
        exp_rd(2'd0, 8'h01, 1'b0, "R2 div5 four ticks hold");
        ticks(1);
        exp_rd(2'd0, 8'h02, 1'b0, "R2 div5 fifth tick");

        // R2: reload of 4 still drains, then divide by 6
        freq50_i = 1'b0;
        ticks(5);
        exp_rd(2'd0, 8'h03, 1'b0, "R2 drain old reload");
        ticks(5);
        exp_rd(2'd0, 8'h03, 1'b0, "R2 div6 five ticks hold");
        ticks(1);
        exp_rd(2'd0, 8'h04, 1'b0, "R2 div6 sixth tick");

        // R5 R7: masked writes, hours write halts the clock
        wr(1'b0, 2'd3, 8'hF1, 1'b0);
        wr(1'b0, 2'd2, 8'hD9, 1'b0);
        wr(1'b0, 2'd1, 8'hD9, 1'b0);
        ticks(7);
        exp_rd(2'd0, 8'h04, 1'b0, "R7 halted ticks ignored");
        exp_rd(2'd3, 8'h91, 1'b0, "R5 hours mask");
        exp_rd(2'd2, 8'h59, 1'b0, "R5 minutes mask");
        exp_rd(2'd1, 8'h59, 1'b0, "R5 seconds mask");
        wr(1'b0, 2'd0, 8'hF9, 1'b0);
        exp_rd(2'd0, 8'h09, 1'b0, "R5 tenths mask");

        // R7 R3 R4 R9: restart; count held at 5 during halt, six ticks to wrap
        freq50_i = 1'b1;
        ticks(5);
        exp_rd(2'd0, 8'h09, 1'b0, "R7 prescaler held while halted");
        ticks_alarm(1, 1'b1, "R9 alarm on wrap to zero time");
        exp_alarm(1'b0, "R9 alarm lasts one cycle");
        exp_time(8'h00, 8'h00, 8'h00, 8'h00, "R4 PM 11 wraps to AM 00");

        // R4: AM 11:59:59.9 -> PM 00
        wr(1'b0, 2'd3, 8'h11, 1'b0);
        wr(1'b0, 2'd2, 8'h59, 1'b0);
        wr(1'b0, 2'd1, 8'h59, 1'b0);
        wr(1'b0, 2'd0, 8'h09, 1'b0);
        ticks_alarm(5, 1'b0, "R9 no alarm on mismatch");
        exp_time(8'h80, 8'h00, 8'h00, 8'h00, "R4 AM 11 wraps to PM 00");

        // R3: hours digit carry 09 -> 10
        wr(1'b0, 2'd3, 8'h09, 1'b0);
        wr(1'b0, 2'd2, 8'h59, 1'b0);
        wr(1'b0, 2'd1, 8'h59, 1'b0);
        wr(1'b0, 2'd0, 8'h09, 1'b0);
        ticks(5);
        exp_time(8'h10, 8'h00, 8'h00, 8'h00, "R3 carry into hours");

        // R3: seconds low digit carry 19 -> 20
        wr(1'b0, 2'd1, 8'h19, 1'b0);
        wr(1'b0, 2'd0, 8'h09, 1'b0);
        ticks(5);
        exp_rd(2'd1, 8'h20, 1'b0, "R3 seconds digit carry");
        exp_rd(2'd0, 8'h00, 1'b0, "R3 tenths wrap");
        wr(1'b0, 2'd1, 8'h00, 1'b0);
        wr(1'b0, 2'd0, 8'h00, 1'b0);

        // R6: alarm writes leave the time alone
        wr(1'b1, 2'd0, 8'hF1, 1'b0);
        wr(1'b1, 2'd1, 8'h00, 1'b0);
        wr(1'b1, 2'd2, 8'h00, 1'b0);
        wr(1'b1, 2'd3, 8'h10, 1'b0);
        exp_alarm(1'b0, "R9 alarm write raises no pulse");
        exp_time(8'h10, 8'h00, 8'h00, 8'h00, "R6 time unchanged by alarm writes");

        // R6 R9: alarm hits on advance to 10:00:00.1
        ticks_alarm(5, 1'b1, "R6 R9 alarm on match");
        exp_alarm(1'b0, "R9 alarm drops");
        exp_rd(2'd0, 8'h01, 1'b0, "R9 tenths at alarm");
        wr(1'b0, 2'd0, 8'h01, 1'b0);
        exp_alarm(1'b0, "R9 write to equal value no pulse");

        // R8: freeze on hours read, clock keeps counting
        exp_rd(2'd3, 8'h10, 1'b1, "R8 hours read");
        ticks(5);
        exp_rd(2'd0, 8'h01, 1'b0, "R8 frozen tenths");
        exp_rd(2'd0, 8'h01, 1'b1, "R8 releasing tenths read");
        exp_rd(2'd0, 8'h02, 1'b0, "R8 live after release");

        // R10: write colliding with an advancing tick drops the tick
        ticks(4);
        wr(1'b0, 2'd1, 8'h30, 1'b1);
        exp_rd(2'd0, 8'h02, 1'b0, "R10 tick dropped");
        exp_rd(2'd1, 8'h30, 1'b0, "R10 write applied");
        ticks(1);
        exp_rd(2'd0, 8'h03, 1'b0, "R10 prescaler held then advances");

        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog actual=timeout expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule